// File: doc/BRIEF.md
# Shadowed Capture-Compare Timer

This block is a 16-bit up-counting timer for motor-control pulse generation. It counts from zero to an active period value, wraps to zero, and compares the running count against a set of active compare values. Software never writes the active period or compare registers directly. Every write lands in a shadow copy, and the shadow contents move into the active registers only on a transfer event. This keeps period and compare changes from tearing a cycle that is already in progress.

A transfer takes place only when a software-set enable flag is armed. The hardware clears the flag after the transfer. In normal mode the transfer event is the period match. In Hall mode, each Hall event captures the live count as a speed reference and restarts the counter, so the period is never reached. For that reason the Hall-driven restart is also a transfer trigger, which lets compare values that set a phase delay be updated on every commutation. While the timer is stopped and the flag is armed, the shadows are transparent.

Top module: `cc_timer`

## Requirements
- R1: After reset the count, the speed reference and the transfer flag are zero. The active and shadow period are all ones, and the active and shadow compare values are zero.
- R2: While run_i is high and no Hall restart occurs, the count goes up by one per cycle. When it equals the active period, it goes to zero on the next edge. While run_i is low the count holds.
- R3: period_match_o is high in exactly those cycles where run_i is high, the count equals the active period, and no Hall restart is taking place.
- R4: cmp_match_o[i] is high in exactly those cycles where run_i is high and the count equals active compare i.
- R5: A write at address 0 loads the period shadow, and a write at address i+1 loads the shadow of compare i. A write at address NUM_CMP+1 sets the transfer flag to data bit 0. With the flag clear, shadow writes leave the active registers unchanged.
- R6: On a trigger with the flag set, every active register takes the value its shadow held before that edge, and the flag clears.
- R7: On a trigger with the flag clear, the active registers keep their values.
- R8: In Hall mode, a Hall event while running loads the pre-edge count into the speed reference and sets the count to zero on the same edge.
- R9: In Hall mode, the Hall-driven restart is a transfer trigger that follows R6 and R7.
- R10: In normal mode (hall_mode_i low), Hall events change neither the count nor the speed reference.
- R11: While run_i is low and the flag is set, each active register takes the value its shadow has after that edge, so a write reaches the active register on the same edge. The flag stays set.
- R12: A flag write on the same edge as a trigger takes precedence over the hardware clear. The transfer itself still happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counter runs while high |
| hall_mode_i | input | 1 | 1 selects Hall mode, 0 selects normal mode |
| hall_evt_i | input | 1 | Detected Hall event, one cycle per event |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | CNT_W | Write data |
| count_o | output | CNT_W | Current count |
| speed_ref_o | output | CNT_W | Captured speed reference |
| period_o | output | CNT_W | Active period |
| cmp_o | output | NUM_CMP*CNT_W | Active compare values, compare i at bits [i*CNT_W +: CNT_W] |
| xfer_en_o | output | 1 | Transfer flag |
| period_match_o | output | 1 | Period match pulse |
| cmp_match_o | output | NUM_CMP | Compare match per channel |

## Verification
The bench sweeps small periods, including zero, against an arithmetic model. An off-by-one in the wrap would show up as a wrong cycle length and as period pulses in the wrong place. Hall restarts are issued at every spacing from one cycle upward. A design that forgot the Hall trigger would leave the phase-delay compare value at its old setting, and one that captured after the reset would report zero speed. Transfers are also attempted with the flag clear, and in the exact cycle of a flag write. A design with the wrong precedence would lose the re-arm, and one that ignored the flag would update the active registers anyway. Writes made while the timer is stopped are checked to reach the active registers on the same edge.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_HALL   = 1'b1
  } tmr_mode_e;

  localparam int unsigned CTRL_ARM_BIT = 0;

  function automatic int unsigned addr_bits(input int unsigned n_cmp);
    return (n_cmp + 2 <= 2) ? 1 : $clog2(n_cmp + 2);
  endfunction
endpackage

// File: rtl/cc_timer_shadow_reg.sv
module cc_timer_shadow_reg #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  input  logic         xfer_i,
  input  logic         transp_i,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o
);
  logic [W-1:0] shadow_q, shadow_d, active_q;

  assign shadow_d = wr_i ? data_i : shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= RST_VAL;
      active_q <= RST_VAL;
    end else begin
      shadow_q <= shadow_d;
      if (xfer_i)        active_q <= shadow_q;  // pre-edge shadow
      else if (transp_i) active_q <= shadow_d;  // same-edge write passes through
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;

  // R7
  no_silent_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_i && !transp_i) |=> $stable(active_q));
  // R6
  xfer_copies_shadow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> (active_q == $past(shadow_q)));
endmodule

// File: rtl/cc_timer_counter.sv
module cc_timer_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hall_rst_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] speed_ref_o,
  output logic             pm_o
);
  logic [CNT_W-1:0] cnt_q, ref_q;
  logic             at_period;

  assign at_period = (cnt_q == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ref_q <= '0;
    end else if (run_i) begin
      if (hall_rst_i) begin
        ref_q <= cnt_q;
        cnt_q <= '0;
      end else if (at_period) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pm_o        = run_i && !hall_rst_i && at_period;
  assign count_o     = cnt_q;
  assign speed_ref_o = ref_q;

  // R2
  hold_when_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));
  // R2
  wrap_at_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_o |=> (cnt_q == '0));
  // R8
  hall_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && hall_rst_i) |=> (cnt_q == '0 && ref_q == $past(cnt_q)));
endmodule

// File: rtl/cc_timer_xfer_ctrl.sv
module cc_timer_xfer_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic trig_i,
  input  logic ctrl_wr_i,
  input  logic ctrl_bit_i,
  output logic arm_o,
  output logic xfer_o,
  output logic transp_o
);
  logic arm_q;

  assign xfer_o   = trig_i && arm_q;
  assign transp_o = !run_i && arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        arm_q <= 1'b0;
    else if (ctrl_wr_i) arm_q <= ctrl_bit_i;  // software write beats hw clear
    else if (xfer_o)    arm_q <= 1'b0;
  end

  assign arm_o = arm_q;

  // R6
  arm_self_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !ctrl_wr_i) |=> !arm_q);
  // R12
  arm_write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> (arm_q == $past(ctrl_bit_i)));
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_CMP = 3,
  parameter int unsigned ADDR_W  = addr_bits(NUM_CMP)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     run_i,
  input  logic                     hall_mode_i,
  input  logic                     hall_evt_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [CNT_W-1:0]         wr_data_i,
  output logic [CNT_W-1:0]         count_o,
  output logic [CNT_W-1:0]         speed_ref_o,
  output logic [CNT_W-1:0]         period_o,
  output logic [NUM_CMP*CNT_W-1:0] cmp_o,
  output logic                     xfer_en_o,
  output logic                     period_match_o,
  output logic [NUM_CMP-1:0]       cmp_match_o
);
  localparam int unsigned CTRL_ADDR = NUM_CMP + 1;

  tmr_mode_e        mode;
  logic             hall_rst, pm, trig, xfer, transp, ctrl_wr;
  logic [CNT_W-1:0] period_act;
  logic [CNT_W-1:0] period_shd;

  assign mode     = tmr_mode_e'(hall_mode_i);
  assign hall_rst = run_i && (mode == MODE_HALL) && hall_evt_i;
  assign trig     = pm || hall_rst;
  assign ctrl_wr  = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_ADDR));

  cc_timer_xfer_ctrl u_xfer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .trig_i     (trig),
    .ctrl_wr_i  (ctrl_wr),
    .ctrl_bit_i (wr_data_i[CTRL_ARM_BIT]),
    .arm_o      (xfer_en_o),
    .xfer_o     (xfer),
    .transp_o   (transp)
  );

  cc_timer_shadow_reg #(.W(CNT_W), .RST_VAL({CNT_W{1'b1}})) u_period (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i && (wr_addr_i == '0)),
    .data_i   (wr_data_i),
    .xfer_i   (xfer),
    .transp_i (transp),
    .shadow_o (period_shd),
    .active_o (period_act)
  );

  cc_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .hall_rst_i  (hall_rst),
    .period_i    (period_act),
    .count_o     (count_o),
    .speed_ref_o (speed_ref_o),
    .pm_o        (pm)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    logic [CNT_W-1:0] act, shd;
    cc_timer_shadow_reg #(.W(CNT_W), .RST_VAL('0)) u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_en_i && (wr_addr_i == ADDR_W'(i + 1))),
      .data_i   (wr_data_i),
      .xfer_i   (xfer),
      .transp_i (transp),
      .shadow_o (shd),
      .active_o (act)
    );
    assign cmp_o[i*CNT_W +: CNT_W] = act;
    assign cmp_match_o[i]          = run_i && (count_o == act);
  end

  assign period_o       = period_act;
  assign period_match_o = pm;

  // R9
  hall_trig_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hall_rst && xfer_en_o) |=> (period_o == $past(period_shd)));
  // R10
  normal_ignores_hall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !hall_mode_i && hall_evt_i && !pm) |=> (count_o == $past(count_o) + 1'b1));
endmodule

// File: tb/tb_cc_timer.sv
module tb_cc_timer;
  localparam int W = 8;
  localparam int NC = 2;
  localparam int AW = 2;
  localparam int MSK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, hm = 0, hall = 0, wr = 0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] data = '0;
  logic [W-1:0] count, sref, per;
  logic [NC*W-1:0] cmp;
  logic xen, pm;
  logic [NC-1:0] cm;

  int checks = 0, failures = 0;
  int m_cnt, m_per, m_sper, m_ref, m_en;
  int m_cmp[NC], m_scmp[NC];

  always #10 clk = ~clk;

  cc_timer #(.CNT_W(W), .NUM_CMP(NC), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .hall_mode_i(hm), .hall_evt_i(hall),
    .wr_en_i(wr), .wr_addr_i(addr), .wr_data_i(data), .count_o(count),
    .speed_ref_o(sref), .period_o(per), .cmp_o(cmp), .xfer_en_o(xen),
    .period_match_o(pm), .cmp_match_o(cm));

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic r, logic h_m, logic h, logic w,
                      logic [AW-1:0] a, logic [W-1:0] d);
    int hr, epm, trig, o_sper;
    int o_scmp[NC];
    @(negedge clk);
    run = r; hm = h_m; hall = h; wr = w; addr = a; data = d;
    #1;
    hr  = (r && h_m && h) ? 1 : 0;
    epm = (r && m_cnt == m_per && !hr) ? 1 : 0;
    chk("R3", "period_match", int'(pm), epm);
    for (int i = 0; i < NC; i++)
      chk("R4", "cmp_match", int'(cm[i]), (r && m_cnt == m_cmp[i]) ? 1 : 0);
    @(posedge clk);
    trig = epm | hr;
    o_sper = m_sper;
    for (int i = 0; i < NC; i++) o_scmp[i] = m_scmp[i];
    if (w && a == 0) m_sper = d;
    for (int i = 0; i < NC; i++) if (w && a == i + 1) m_scmp[i] = d;
    if (r) begin
      if (hr) begin m_ref = m_cnt; m_cnt = 0; end
      else if (m_cnt == m_per) m_cnt = 0;
      else m_cnt = (m_cnt + 1) & MSK;
    end
    if (trig && m_en) begin
      m_per = o_sper;
      for (int i = 0; i < NC; i++) m_cmp[i] = o_scmp[i];
    end else if (!r && m_en) begin
      m_per = m_sper;
      for (int i = 0; i < NC; i++) m_cmp[i] = m_scmp[i];
    end
    if (w && a == NC + 1) m_en = d[0];
    else if (trig && m_en) m_en = 0;
    #1;
    chk(tag, "count", int'(count), m_cnt);
    chk(tag, "speed_ref", int'(sref), m_ref);
    chk(tag, "xfer_en", int'(xen), m_en);
    chk(tag, "period", int'(per), m_per);
    for (int i = 0; i < NC; i++) chk(tag, "cmp", int'(cmp[i*W +: W]), m_cmp[i]);
  endtask

  task automatic idle(string tag, logic r, logic h_m, int n);
    for (int k = 0; k < n; k++) step(tag, r, h_m, 1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_cnt = 0; m_per = MSK; m_sper = MSK; m_ref = 0; m_en = 0;
    for (int i = 0; i < NC; i++) begin m_cmp[i] = 0; m_scmp[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "count", int'(count), 0);
    chk("R1", "speed_ref", int'(sref), 0);
    chk("R1", "xfer_en", int'(xen), 0);
    chk("R1", "period", int'(per), MSK);
    chk("R1", "cmp0", int'(cmp[0 +: W]), 0);
    chk("R1", "period_match", int'(pm), 0);
    @(negedge clk); rst_n = 1'b1;

    // R5: shadow writes with flag clear leave active untouched
    step("R5", 0, 0, 0, 1, 2'd0, 8'd5);
    step("R5", 0, 0, 0, 1, 2'd1, 8'd2);
    step("R5", 0, 0, 0, 1, 2'd2, 8'd4);
    idle("R5", 0, 0, 2);

    // R11: transparent while stopped and armed
    step("R11", 0, 0, 0, 1, 2'd3, 8'd1);
    idle("R11", 0, 0, 1);
    step("R11", 0, 0, 0, 1, 2'd2, 8'd3);
    step("R11", 0, 0, 0, 1, 2'd0, 8'd6);
    step("R11", 0, 0, 0, 1, 2'd3, 8'd0);

    // R7: running, flag clear, shadow change does not transfer at wrap
    step("R7", 1, 0, 0, 1, 2'd0, 8'd3);
    idle("R7", 1, 0, 16);
    // R6: arm, next period match transfers and clears
    step("R6", 1, 0, 0, 1, 2'd3, 8'd1);
    idle("R6", 1, 0, 16);
    // R2: hold while stopped
    idle("R2", 0, 0, 5);

    // R2/R3/R4 sweep over periods, compares at boundaries
    for (int p = 0; p < 8; p++) begin
      step("R2", 0, 0, 0, 1, 2'd0, 8'(p));
      step("R2", 0, 0, 0, 1, 2'd1, 8'(p / 2));
      step("R2", 0, 0, 0, 1, 2'd2, 8'(p));
      step("R2", 0, 0, 0, 1, 2'd3, 8'd1);
      step("R2", 0, 0, 0, 1, 2'd3, 8'd0);
      for (int k = 0; k < 300 && m_cnt != 0; k++) idle("R2", 1, 0, 1);
      idle("R2", 1, 0, 3 * (p + 1) + 1);
    end

    // R10: Hall events in normal mode are ignored
    for (int k = 0; k < 12; k++) step("R10", 1, 0, 1, 0, '0, '0);

    // R8: Hall restarts at various spacings
    step("R8", 0, 1, 0, 1, 2'd0, 8'd200);
    step("R8", 0, 1, 0, 1, 2'd3, 8'd1);
    step("R8", 0, 1, 0, 1, 2'd3, 8'd0);
    for (int s = 1; s <= 7; s++) begin
      idle("R8", 1, 1, s - 1);
      step("R8", 1, 1, 1, 0, '0, '0);
    end
    step("R8", 1, 1, 1, 0, '0, '0);

    // R9: Hall restart as trigger, flag clear then armed
    step("R9", 1, 1, 0, 1, 2'd1, 8'd9);
    idle("R9", 1, 1, 4);
    step("R9", 1, 1, 1, 0, '0, '0);
    step("R9", 1, 1, 0, 1, 2'd3, 8'd1);
    idle("R9", 1, 1, 3);
    step("R9", 1, 1, 1, 0, '0, '0);
    step("R9", 1, 1, 0, 1, 2'd2, 8'd4);
    idle("R9", 1, 1, 2);
    step("R9", 1, 1, 1, 0, '0, '0);
    idle("R9", 1, 1, 12);

    // R12: flag write in the trigger cycle
    step("R12", 1, 0, 0, 1, 2'd0, 8'd4);
    step("R12", 1, 0, 0, 1, 2'd3, 8'd1);
    for (int k = 0; k < 300 && m_cnt != m_per; k++) idle("R12", 1, 0, 1);
    step("R12", 1, 0, 0, 1, 2'd3, 8'd1);
    step("R12", 1, 0, 0, 1, 2'd1, 8'd3);
    for (int k = 0; k < 300 && m_cnt != m_per; k++) idle("R12", 1, 0, 1);
    step("R12", 1, 0, 0, 1, 2'd3, 8'd0);
    idle("R12", 1, 0, 10);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule